// File: doc/BRIEF.md
# Montgomery domain factor generator

This block computes the constant 2^(2·W·L) mod N that converts operands into the Montgomery domain. N is an odd modulus of L words, each W bits wide. N is read from an external synchronous-read word memory, least significant word first. The result is kept in an internal word buffer. Once the block is idle, the result can be read one word at a time through a combinational read port.

A run begins with a one-cycle `start` while the block is idle. The word count `len` is captured on that same edge. The block then performs 2·W·L rounds. In each round the current value is doubled, one word per cycle, with the bit leaving each word fed into the bottom of the next word. In the same cycle that word of N is subtracted through a one-bit borrow chain. At the end of the round, the doubled value is kept if it lies below N. Otherwise the difference becomes the new value. The two candidates are held in separate buffers, and the choice between them costs no extra cycle.

N is fetched once at the start of the run. After that, word fetches run back to back across round boundaries, so a round takes L cycles and a run takes 2·W·L·L + 1 cycles from the start edge to the last edge.

Top module: `mont_factor_gen`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every word on the result read port reads 0.
- R2: On a `start` sampled while idle, `len` is latched and `busy` is 1 from the next cycle. In the cycle that follows the t-th edge after the start edge (t = 0 being the start edge), `n_rd_addr` equals t mod L for as long as `busy` is 1. The N memory returns the word one cycle after its address.
- R3: For odd N with 1 < N < 2^(W·L), result words 0..L-1 read, least significant first, the value 2^(2·W·L) mod N.
- R4: The run takes exactly 2·W·L rounds of L cycles each. `busy` is 1 in the cycles after edges 0..2·W·L·L and 0 after edge 2·W·L·L + 1.
- R5: `done` is 1 only in the cycle after edge 2·W·L·L + 1, for exactly one cycle.
- R6: Result words at indices L and above read 0 after a run.
- R7: A `start` sampled while `busy` is 1 is ignored, even when `len` changes with it. Neither the timing nor the result of the run in progress is affected.
- R8: The bit carried out of each word's top during doubling, and the borrow, are both cleared at the start of every round. A carry out of the top word forces the subtraction. This covers moduli with their top bit set and moduli whose upper words are zero.
- R9: Every accepted `start` re-initialises the value to 1. Words left over from an earlier, longer run read 0 after a shorter run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| len | input | $clog2(MAX_WORDS+1) | Number of words L, 1..MAX_WORDS |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the last round |
| n_rd_addr | output | AW | Word address into the modulus memory |
| n_rd_data | input | WORD_W | Modulus word, one cycle after its address |
| f_rd_addr | input | AW | Result word index |
| f_rd_data | output | WORD_W | Result word, combinational from `f_rd_addr` |

## Verification
The hardest case to reach is a round in which doubling pushes a bit out of the top word. In that case the borrow is also set, and only the carry tells the block to subtract. The stimulus reaches it with moduli whose top bit is set, such as all-ones and 0x8000_0001 patterns. With those moduli the running value regularly exceeds 2^(W·L-1). Moduli whose upper words are zero, and a short run after a long one, exercise the chains across empty words and stale buffer contents. The bench predicts `busy`, `done` and the fetch address every clock from the cycle count alone. It checks every result word against a wide-integer remainder.

// File: rtl/mfg_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the Montgomery factor generator.
// Assumes nothing beyond IEEE 1800-2017.
package mfg_pkg;

    // Sequencer states: idle, first modulus fetch, word pass.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PASS  = 2'd2
    } mfg_state_e;

endpackage

// File: rtl/mfg_ctrl.sv
`timescale 1ns/1ps
// Module: mfg_ctrl
// Sequences a run. It captures the word count, steps the word index over
// 0..L-1 for each round, counts 2*W*L rounds, and prefetches modulus words
// one cycle ahead. The address wraps to 0 on the last word, so the next
// round starts without a bubble.
// Assumes: len is 1..MAX_WORDS when start is sampled while idle.
module mfg_ctrl
    import mfg_pkg::*;
#(
    parameter  int WORD_W    = 16,
    parameter  int MAX_WORDS = 8,
    localparam int LW        = $clog2(MAX_WORDS + 1),
    localparam int AW        = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len_in,
    output logic          busy,
    output logic          done,
    output logic          init,
    output logic          step,
    output logic          round_end,
    output logic [AW-1:0] word_idx,
    output logic [AW-1:0] rd_addr,
    output logic [LW-1:0] len_q
);

    localparam int RW = $clog2(2 * WORD_W * MAX_WORDS + 1);

    mfg_state_e    state_q;
    logic [LW-1:0] j_q;
    logic [LW-1:0] addr_q;
    logic [RW-1:0] rnd_q;
    logic          done_q;

    logic [LW-1:0] addr_next;
    logic [RW-1:0] rounds_total;
    logic          last_word;
    logic          last_round;

    // Next fetch address, last word, and last round.
    always_comb begin
        addr_next    = (addr_q == len_q - LW'(1)) ? '0 : addr_q + LW'(1);
        last_word    = (j_q == len_q - LW'(1));
        rounds_total = RW'(len_q) * RW'(2 * WORD_W);
        last_round   = (rnd_q == rounds_total - RW'(1));
    end

    // Sequencer: state, word index, fetch address, round counter, done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            j_q     <= '0;
            addr_q  <= '0;
            rnd_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        len_q   <= len_in;
                        j_q     <= '0;
                        addr_q  <= '0;
                        rnd_q   <= '0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    addr_q  <= addr_next;
                    state_q <= ST_PASS;
                end
                ST_PASS: begin
                    addr_q <= addr_next;
                    if (last_word) begin
                        j_q <= '0;
                        if (last_round) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            rnd_q <= rnd_q + RW'(1);
                        end
                    end else begin
                        j_q <= j_q + LW'(1);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = done_q;
        init      = (state_q == ST_IDLE) && start;
        step      = (state_q == ST_PASS);
        round_end = step && last_word;
        word_idx  = j_q[AW-1:0];
        rd_addr   = addr_q[AW-1:0];
    end

    // R5: done never lasts two cycles.
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: done comes right after the run, which leaves busy low.
    p_done_ends_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R2: an accepted start makes the block busy on the next cycle.
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: the fetch address stays inside the modulus while busy.
    p_addr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (addr_q < len_q));

    // R7: a start during a run leaves the latched length alone.
    p_len_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q));

endmodule

// File: rtl/mfg_word_alu.sv
`timescale 1ns/1ps
// Module: mfg_word_alu
// Per-word datapath. It doubles the current word, taking in the bit
// carried from the word below. It also subtracts the matching modulus word
// with the running borrow. The one-bit carry and borrow chain flops live
// here. They clear when a run starts and again at the end of each round.
// Assumes: step is high exactly in word-pass cycles, and round_end marks
// the last word of a round.
module mfg_word_alu #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              step,
    input  logic              round_end,
    input  logic [WORD_W-1:0] cur_word,
    input  logic [WORD_W-1:0] n_word,
    output logic [WORD_W-1:0] shifted,
    output logic [WORD_W-1:0] diff,
    output logic              keep_shift
);

    logic          cy_q;
    logic          bw_q;
    logic          cy_out;
    logic          bw_out;
    logic [WORD_W:0] d_ext;

    // Doubling with carry-in, and subtraction with borrow-in.
    always_comb begin
        shifted    = (cur_word << 1) | WORD_W'(cy_q);
        cy_out     = cur_word[WORD_W-1];
        d_ext      = {1'b0, shifted} - {1'b0, n_word} - (WORD_W + 1)'(bw_q);
        diff       = d_ext[WORD_W-1:0];
        bw_out     = d_ext[WORD_W];
        keep_shift = bw_out && !cy_out;
    end

    // Chain flops: pass carry and borrow word to word, clear at round end.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            cy_q <= 1'b0;
            bw_q <= 1'b0;
        end else if (step) begin
            if (round_end) begin
                cy_q <= 1'b0;
                bw_q <= 1'b0;
            end else begin
                cy_q <= cy_out;
                bw_q <= bw_out;
            end
        end
    end

    // R8: outside the word pass the chains sit at zero, so every round starts clean.
    p_chain_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> (!cy_q && !bw_q));

    // R8: a carry out of the top word always selects the difference.
    p_carry_forces_sub_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (round_end && cur_word[WORD_W-1]) |-> !keep_shift);

endmodule

// File: rtl/mfg_factor_buf.sv
`timescale 1ns/1ps
// Module: mfg_factor_buf
// Holds two word buffers: the doubled candidate and the difference
// candidate. A select flag marks which buffer holds the current value.
// Each pass reads word j from the selected buffer and writes both
// candidates back at j. The flag is then set from the end-of-round
// decision, so no copy pass is needed.
// Assumes: wr_idx < len during writes; the read port is used while idle.
module mfg_factor_buf #(
    parameter  int WORD_W    = 16,
    parameter  int MAX_WORDS = 8,
    localparam int LW        = $clog2(MAX_WORDS + 1),
    localparam int AW        = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              wr_en,
    input  logic              commit,
    input  logic              keep_shift,
    input  logic [LW-1:0]     len,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] shifted,
    input  logic [WORD_W-1:0] diff,
    output logic [WORD_W-1:0] cur_word,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] sh_q [MAX_WORDS];
    logic [WORD_W-1:0] df_q [MAX_WORDS];
    logic              sel_sh_q;

    // Current-value word feeding the datapath.
    always_comb begin
        cur_word = sel_sh_q ? sh_q[wr_idx] : df_q[wr_idx];
    end

    // Result read port; indices past the buffer read zero.
    always_comb begin
        if (int'(rd_addr) < MAX_WORDS) begin
            rd_data = sel_sh_q ? sh_q[rd_addr] : df_q[rd_addr];
        end else begin
            rd_data = '0;
        end
    end

    // Buffer writes, initialisation to one, and select update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MAX_WORDS; i++) begin
                sh_q[i] <= '0;
                df_q[i] <= '0;
            end
            sel_sh_q <= 1'b1;
        end else if (init) begin
            for (int i = 0; i < MAX_WORDS; i++) begin
                sh_q[i] <= (i == 0) ? WORD_W'(1) : '0;
                df_q[i] <= '0;
            end
            sel_sh_q <= 1'b1;
        end else begin
            if (wr_en) begin
                sh_q[wr_idx] <= shifted;
                df_q[wr_idx] <= diff;
            end
            if (commit) begin
                sel_sh_q <= keep_shift;
            end
        end
    end

    // R6: writes never reach words at or above the run length.
    p_wr_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (LW'(wr_idx) < len));

    // R9: an accepted start leaves the value equal to one.
    p_init_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (sel_sh_q && sh_q[0] == WORD_W'(1)));

endmodule

// File: rtl/mont_factor_gen.sv
`timescale 1ns/1ps
// Module: mont_factor_gen (top)
// Computes 2^(2*W*L) mod N by 2*W*L rounds of doubling with a conditional
// subtraction, one word per cycle. N comes from a synchronous-read
// memory with one-cycle latency. The result stays in an internal buffer
// and is read combinationally while idle.
// Assumes: N odd, 1 < N < 2^(W*L), memory content stable during a run.
module mont_factor_gen #(
    parameter  int WORD_W    = 16,
    parameter  int MAX_WORDS = 8,
    localparam int LW        = $clog2(MAX_WORDS + 1),
    localparam int AW        = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LW-1:0]     len,
    output logic              busy,
    output logic              done,
    output logic [AW-1:0]     n_rd_addr,
    input  logic [WORD_W-1:0] n_rd_data,
    input  logic [AW-1:0]     f_rd_addr,
    output logic [WORD_W-1:0] f_rd_data
);

    logic              init;
    logic              step;
    logic              round_end;
    logic [AW-1:0]     word_idx;
    logic [LW-1:0]     len_q;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] shifted;
    logic [WORD_W-1:0] diff;
    logic              keep_shift;

    mfg_ctrl #(
        .WORD_W    (WORD_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len_in    (len),
        .busy      (busy),
        .done      (done),
        .init      (init),
        .step      (step),
        .round_end (round_end),
        .word_idx  (word_idx),
        .rd_addr   (n_rd_addr),
        .len_q     (len_q)
    );

    mfg_word_alu #(
        .WORD_W (WORD_W)
    ) u_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .step       (step),
        .round_end  (round_end),
        .cur_word   (cur_word),
        .n_word     (n_rd_data),
        .shifted    (shifted),
        .diff       (diff),
        .keep_shift (keep_shift)
    );

    mfg_factor_buf #(
        .WORD_W    (WORD_W),
        .MAX_WORDS (MAX_WORDS)
    ) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .wr_en      (step),
        .commit     (round_end),
        .keep_shift (keep_shift),
        .len        (len_q),
        .wr_idx     (word_idx),
        .shifted    (shifted),
        .diff       (diff),
        .cur_word   (cur_word),
        .rd_addr    (f_rd_addr),
        .rd_data    (f_rd_data)
    );

endmodule

// File: tb/mont_factor_gen_tb.sv
`timescale 1ns/1ps
// Bench for mont_factor_gen: predicts busy, done and the fetch address every
// clock from a cycle count, and checks each result word against a
// wide-integer remainder.
module mont_factor_gen_tb;

    localparam int W    = 16;
    localparam int MW   = 8;
    localparam int LW   = $clog2(MW + 1);
    localparam int AW   = $clog2(MW);
    localparam int BIGW = 2 * W * MW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] len = '0;
    logic          busy;
    logic          done;
    logic [AW-1:0] n_rd_addr;
    logic [W-1:0]  n_rd_data;
    logic [AW-1:0] f_rd_addr = '0;
    logic [W-1:0]  f_rd_data;

    logic [W-1:0]  nmem [MW];
    int            n_checks = 0;
    int            n_fail = 0;
    int            prev_len = 0;

    always #10 clk = ~clk;

    mont_factor_gen #(.WORD_W(W), .MAX_WORDS(MW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .len       (len),
        .busy      (busy),
        .done      (done),
        .n_rd_addr (n_rd_addr),
        .n_rd_data (n_rd_data),
        .f_rd_addr (f_rd_addr),
        .f_rd_data (f_rd_data)
    );

    // Modulus memory: synchronous read, one cycle of latency.
    always @(posedge clk) n_rd_data <= nmem[n_rd_addr];

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One run: load N, start, follow the cycle model, then read the result.
    task automatic run_job(input int ln, input logic [W*MW-1:0] nval, input bit poke);
        logic [BIGW-1:0] nb;
        logic [BIGW-1:0] rf;
        int rounds;
        int last;
        nb = '0;
        for (int i = 0; i < MW; i++) begin
            nmem[i] = (i < ln) ? nval[i*W +: W] : '0;
            if (i < ln) nb[i*W +: W] = nval[i*W +: W];
        end
        rf = (BIGW'(1) << (2 * W * ln)) % nb;
        rounds = 2 * W * ln;
        last = rounds * ln + 1;
        @(negedge clk);
        start = 1'b1;
        len = LW'(ln);
        @(negedge clk);
        for (int t = 0; t <= last + 1; t++) begin
            if (t == 0) start = 1'b0;
            if (poke && t == 3) begin   // R7 stimulus: start with another length
                start = 1'b1;
                len = LW'((ln == MW) ? 1 : MW);
            end
            if (poke && t == 7) begin
                start = 1'b0;
                len = LW'(ln);
            end
            #1;
            chk("R4 busy", 64'(busy), 64'(t <= rounds * ln));
            chk(poke ? "R7 done" : "R5 done", 64'(done), 64'(t == last));
            if (t <= rounds * ln) chk("R2 addr", 64'(n_rd_addr), 64'(t % ln));
            @(negedge clk);
        end
        for (int i = 0; i < MW; i++) begin
            f_rd_addr = AW'(i);
            #1;
            if (i < ln) chk(poke ? "R7 word" : "R3 word", 64'(f_rd_data), 64'(rf[i*W +: W]));
            else if (i < prev_len) chk("R9 stale word", 64'(f_rd_data), 64'd0);
            else chk("R6 upper word", 64'(f_rd_data), 64'd0);
        end
        prev_len = ln;
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MW; i++) nmem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        for (int i = 0; i < MW; i++) begin
            f_rd_addr = AW'(i);
            #1;
            chk("R1 word", 64'(f_rd_data), 64'd0);
        end
        // R3: single-word moduli
        run_job(1, (W*MW)'(16'hFFF1), 1'b0);
        run_job(1, (W*MW)'(16'h0003), 1'b0);
        // R8: top bit set, carry out of the top word
        run_job(2, (W*MW)'(32'hFFFF_FFFF), 1'b0);
        run_job(2, (W*MW)'(32'h8000_0001), 1'b0);
        // R8: upper modulus words zero
        run_job(3, (W*MW)'(48'h0000_0000_0035), 1'b0);
        // R7: start during a run
        run_job(4, (W*MW)'(64'hC3A5_0F1E_9B7D_2469), 1'b1);
        // R3: full width
        run_job(8, 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F, 1'b0);
        // R9: short run after a long one
        run_job(2, (W*MW)'(32'h9E37_79B1), 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule